// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block is a small control state machine that walks a root-port link from reset to its final speed. On a start pulse it first limits the advertised maximum speed to the first generation and only then lets the training state machine run. Once the link reports up, it raises the limit to the second generation, issues a one-cycle directed speed-change request, and waits until the speed-change status clears. A second link-up wait follows before success is reported.

Each wait is a bounded poll. A poll happens once every `POLL_GAP + 1` cycles, and the first poll lands `POLL_GAP + 1` cycles after the wait begins. At most `POLL_LIMIT` polls are allowed before the sequence gives up. The result is a one-cycle `done` or `fail` pulse. On success the generation that the link reports is latched on `neg_gen`.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset `speed_cap`, `ltssm_en`, `spd_chg_req`, `done`, `fail` and `neg_gen` are all 0.
- R2: A start accepted in the idle state sets `speed_cap` to 1 (first generation) and clears `ltssm_en` and `neg_gen` on the next edge. `ltssm_en` rises one edge later, with `speed_cap` already at 1.
- R3: In each wait the first poll is taken at the edge `POLL_GAP + 1` cycles after the wait is entered. Later polls follow every `POLL_GAP + 1` cycles. The first link wait is entered at the edge that raises `ltssm_en`.
- R4: The edge after the first successful link poll sets `speed_cap` to 2 and raises `spd_chg_req` for exactly one cycle. The speed-change wait is entered at that edge.
- R5: The speed-change wait succeeds at the first poll that sees `spd_chg_busy` low. If `POLL_LIMIT` polls all see it high, `fail` pulses at the last poll and no second link wait takes place.
- R6: The second link wait is entered at the edge of the successful speed-change poll. `done` pulses at its first poll that sees `link_up` high.
- R7: `neg_gen` takes the value of `link_gen` at the edge that raises `done`. It holds that value until the next accepted start.
- R8: `done` and `fail` are one-cycle pulses, never high together. Exactly one of them follows each accepted start.
- R9: `start` is ignored while a sequence is running. Timing and outcome are the same as without the extra pulse.
- R10: A link wait that sees `link_up` low on all `POLL_LIMIT` polls pulses `fail` at the last poll. After a failure in the first link wait, `speed_cap` stays 1 and `neg_gen` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up sequence (accepted when idle) |
| link_up | input | 1 | Link reports up and out of training |
| spd_chg_busy | input | 1 | Directed speed change still in progress |
| link_gen | input | GEN_W | Current link generation from link status |
| speed_cap | output | GEN_W | Maximum link speed field (1 = first gen, 2 = second gen) |
| ltssm_en | output | 1 | Enable for the training state machine |
| spd_chg_req | output | 1 | One-cycle directed speed-change request |
| done | output | 1 | Success pulse |
| fail | output | 1 | Failure pulse |
| neg_gen | output | GEN_W | Generation latched on success |

## Verification
The hardest case to reach is a failure exactly at the final permitted poll of the speed-change or second link wait. Reaching it needs a link that came up once and then either stays busy or drops for just long enough. The bench drives `link_up` and `spd_chg_busy` from edge-count thresholds, and sweeps each threshold across every poll slot and one past the last. For each setting it computes the poll edges arithmetically, so both the outcome and the edge at which it appears are predicted.

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int POLL_LIMIT = 200,
  parameter int POLL_GAP   = 100,
  parameter int GEN_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             link_up,
  input  logic             spd_chg_busy,
  input  logic [GEN_W-1:0] link_gen,
  output logic [GEN_W-1:0] speed_cap,
  output logic             ltssm_en,
  output logic             spd_chg_req,
  output logic             done,
  output logic             fail,
  output logic [GEN_W-1:0] neg_gen
);

  localparam int GW = $clog2(POLL_GAP + 2);
  localparam int NW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_CAP1, S_WAIT1, S_CAP2, S_SPD, S_WAIT2} st_t;

  st_t           state;
  logic [GW-1:0] gap;
  logic [NW-1:0] polls;

  logic tick, ok, last;
  assign tick = (gap == '0);
  assign ok   = (state == S_SPD) ? !spd_chg_busy : link_up;
  assign last = (polls == NW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      speed_cap   <= '0;
      ltssm_en    <= 1'b0;
      spd_chg_req <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      neg_gen     <= '0;
      gap         <= '0;
      polls       <= '0;
    end else begin
      done        <= 1'b0;
      fail        <= 1'b0;
      spd_chg_req <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          speed_cap <= GEN_W'(1);
          ltssm_en  <= 1'b0;
          neg_gen   <= '0;
          state     <= S_CAP1;
        end
        S_CAP1: begin
          ltssm_en <= 1'b1;
          gap      <= GW'(POLL_GAP);
          polls    <= '0;
          state    <= S_WAIT1;
        end
        S_CAP2: begin
          speed_cap   <= GEN_W'(2);
          spd_chg_req <= 1'b1;
          gap         <= GW'(POLL_GAP);
          polls       <= '0;
          state       <= S_SPD;
        end
        default: begin
          if (!tick) begin
            gap <= gap - 1'b1;
          end else if (ok) begin
            if (state == S_WAIT1) begin
              state <= S_CAP2;
            end else if (state == S_SPD) begin
              gap   <= GW'(POLL_GAP);
              polls <= '0;
              state <= S_WAIT2;
            end else begin
              done    <= 1'b1;
              neg_gen <= link_gen;
              state   <= S_IDLE;
            end
          end else if (last) begin
            fail  <= 1'b1;
            state <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
            gap   <= GW'(POLL_GAP);
          end
        end
      endcase
    end
  end

  AST_CAP_BEFORE_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en) |-> (speed_cap == GEN_W'(1)) && ($past(speed_cap) == GEN_W'(1))); // R2
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    polls < NW'(POLL_LIMIT)); // R3
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_req |=> !spd_chg_req); // R4
  AST_REQ_AT_GEN2: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_req |-> speed_cap == GEN_W'(2)); // R4
  AST_DONE_AT_GEN2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (speed_cap == GEN_W'(2)) && ltssm_en); // R6
  AST_GEN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> neg_gen == $past(link_gen)); // R7
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> !(done || fail)); // R8

endmodule

// File: tb/link_bringup_seq_tb.sv
module link_bringup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 4;
  localparam int GAP = 2;
  localparam int G = GAP + 1;

  logic clk = 0, rst_n = 0, start = 0, link_up = 0, spd_chg_busy = 0;
  logic [3:0] link_gen = 0;
  logic [3:0] speed_cap, neg_gen;
  logic ltssm_en, spd_chg_req, done, fail;

  int checks = 0, errors = 0, cyc = 0;
  int up1, drop, up2, clr, rst_at;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_bringup_seq #(.POLL_LIMIT(LIM), .POLL_GAP(GAP), .GEN_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
    .spd_chg_busy(spd_chg_busy), .link_gen(link_gen), .speed_cap(speed_cap),
    .ltssm_en(ltssm_en), .spd_chg_req(spd_chg_req), .done(done), .fail(fail),
    .neg_gen(neg_gen));

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit linkf(input int e);
    return (e >= up1 && e < drop) || e >= up2;
  endfunction

  // expected outcome: kind 0 = done, 1 = fail in wait1, 2 = fail in spd, 3 = fail in wait2
  task automatic predict(output int kind, output int edge_n, output int reqs);
    int e1, e2, s;
    bit hit;
    hit = 0; e1 = 0;
    for (int k = 0; k < LIM; k++) if (!hit && linkf(1 + (k+1)*G)) begin hit = 1; e1 = 1 + (k+1)*G; end
    if (!hit) begin kind = 1; edge_n = 1 + LIM*G; reqs = 0; return; end
    reqs = 1;
    s = e1 + 1; hit = 0; e2 = 0;
    for (int k = 0; k < LIM; k++) if (!hit && (s + (k+1)*G) >= clr) begin hit = 1; e2 = s + (k+1)*G; end
    if (!hit) begin kind = 2; edge_n = s + LIM*G; return; end
    hit = 0;
    for (int k = 0; k < LIM; k++) if (!hit && linkf(e2 + (k+1)*G)) begin hit = 1; edge_n = e2 + (k+1)*G; end
    if (!hit) begin kind = 3; edge_n = e2 + LIM*G; return; end
    kind = 0;
  endtask

  task automatic run(input int gen);
    int cnt, kind, exp_edge, exp_reqs, reqs, got_kind;
    bit seen_req;
    predict(kind, exp_edge, exp_reqs);
    link_gen = 4'(gen);
    @(negedge clk);
    start = 1; cnt = 0; reqs = 0; seen_req = 0; got_kind = -1;
    link_up = linkf(0); spd_chg_busy = 0;
    while (cnt < 200) begin
      @(negedge clk);
      start = (rst_at != 0 && cnt + 1 == rst_at);
      if (cnt == 1) chk(ltssm_en && speed_cap == 1, "R2 train after cap", speed_cap, 1);
      if (spd_chg_req) begin reqs++; seen_req = 1;
        chk(speed_cap == 2, "R4 cap at request", speed_cap, 2); end
      if (done || fail) begin got_kind = done ? 0 : 1;
        chk(!(done && fail), "R8 exclusive", done, 0); break; end
      cnt++;
      link_up = linkf(cnt);
      spd_chg_busy = seen_req && cnt < clr;
    end
    start = 0;
    chk(got_kind == (kind == 0 ? 0 : 1), "R5 R6 R10 outcome", got_kind, kind);
    chk(cnt == exp_edge, rst_at != 0 ? "R9 timing with extra start" : "R3 result edge", cnt, exp_edge);
    chk(reqs == exp_reqs, "R4 request count", reqs, exp_reqs);
    if (kind == 0) begin
      chk(neg_gen == 4'(gen), "R7 gen latched", neg_gen, gen);
    end else begin
      chk(neg_gen == 0, "R7 gen cleared", neg_gen, 0);
      if (kind == 1) chk(speed_cap == 1, "R10 cap stays gen1", speed_cap, 1);
    end
    @(negedge clk);
    chk(!done && !fail, "R8 one cycle pulse", done | fail, 0);
    link_gen = 4'hF;
    repeat (3) @(negedge clk);
    if (kind == 0) chk(neg_gen == 4'(gen), "R7 gen held", neg_gen, gen);
  endtask

  initial begin
    rst_at = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(speed_cap == 0 && !ltssm_en && !spd_chg_req && !done && !fail && neg_gen == 0,
        "R1 reset state", {speed_cap, ltssm_en, done, fail}, 0);
    // first link wait sweep
    for (int u = 0; u < 17; u++) begin
      up1 = u; drop = 100000; up2 = 100000; clr = 0;
      run(u % 3 + 1);
    end
    // speed-change completion sweep
    for (int c = 0; c < 23; c++) begin
      up1 = 0; drop = 100000; up2 = 100000; clr = c;
      run(2);
    end
    // second link wait sweep: link drops after first poll
    for (int u = 5; u < 26; u++) begin
      up1 = 0; drop = 5; up2 = u; clr = 0;
      run(u % 2 + 1);
    end
    // extra start pulses while running
    up1 = 6; drop = 100000; up2 = 100000; clr = 12; rst_at = 9;
    run(2);
    rst_at = 3; up1 = 20;
    run(1);
    rst_at = 0;
    summary();
    $finish;
  end
endmodule